// File: doc/BRIEF.md
# Run-Length Byte Packer for a Transmit FIFO

This block sits between the byte write buffer of a parallel-port peripheral and its transmit FIFO and squeezes runs of equal bytes. Every accepted byte moves through two holding registers, an older and a newer one. Two equality comparators look at the older and newer registers, and at the newer register and the byte being offered. When all three are equal, the block starts counting instead of forwarding. A run leaves the block as a count entry followed by one literal copy of the byte. Bytes that do not repeat pass through unchanged.

Each FIFO entry is one bit wider than a byte. The top bit tags the entry as a count (1) or a literal (0). A receiver that sees a count `n` emits `n+1` copies of the literal that follows it. The two newest bytes stay inside the block while the writer is idle, so that a run can carry on across write bursts. The pipeline empties only on a release condition, which is compression switched off or both the DMA enable and the buffer write enable low. A full FIFO stalls the writer through `wr_ready`.

Top module: `rle_tx_packer`

## Requirements
- R1: A synchronous reset empties both holding registers and clears the run counter. After reset `fifo_wr` is 0, `wr_ready` is 1, and idle cycles write nothing to the FIFO.
- R2: `fifo_data[8]` is 1 for a count entry, with the count in `fifo_data[6:0]` and `fifo_data[7]` zero. It is 0 for a literal, with the byte in `fifo_data[7:0]`. A count entry is never 0, and the next FIFO entry after a count is always a literal.
- R3: A run starts only when the older register, the newer register and the offered byte are all equal. The cycle that starts a run writes nothing. Two equal bytes followed by a different one come out as plain literals.
- R4: Decoding the FIFO stream (a count `n` expands to `n+1` copies of the following literal) gives back exactly the bytes that were written, in the same order.
- R5: While a run is open, a different offered byte closes it. The block writes the count, then the older held byte as a literal, and then takes the new byte.
- R6: A run's count stops at 127. The next equal byte closes the run as in R5, and a longer run becomes more than one count/literal pair. After a close, a new run needs three equal bytes again.
- R7: With `wr_en` low and no release condition, the last two bytes stay held and nothing is written. Clearing only one of `dma_en` or `buf_we_en` does not release the pipeline.
- R8: When `comp_en` is 0, or when `dma_en` and `buf_we_en` are both 0, and no byte is offered, the block drains one entry per cycle. It first writes any open count, then the older byte, then the newer byte.
- R9: With `comp_en` at 0, every byte goes out as a literal, in order, and no count entry is produced.
- R10: While `fifo_full` is 1, `fifo_wr` and `wr_ready` are both 0. No byte is lost or duplicated across the stall.
- R11: When an offered byte closes a run, `wr_ready` is 0 for exactly the one cycle in which the count is written. The byte is accepted in the next cycle, together with the literal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| comp_en | input | 1 | Compression enable |
| dma_en | input | 1 | DMA transfer enable |
| buf_we_en | input | 1 | Write-buffer enable |
| wr_en | input | 1 | A byte is offered on `wr_data` |
| wr_data | input | 8 | Offered byte |
| wr_ready | output | 1 | The offered byte is accepted at this clock edge |
| fifo_full | input | 1 | The transmit FIFO cannot take an entry |
| fifo_wr | output | 1 | Write strobe to the FIFO |
| fifo_data | output | 9 | FIFO entry: tag bit 8, payload bits 7:0 |

## Verification
The bench targets the length boundary with a 131-byte run. A counter that wrapped past 127 or skipped the literal after the cap would decode to the wrong length, and a design that went on counting right after the close would merge the tail into one pair. A triple run closed by a different byte checks the one-cycle stall and the count-then-older-byte order; swapping that order or losing the incoming byte shows up as a wrong sequence. Two equal bytes must stay literals, so a compressor that fires on a pair produces a stray count. The bench also covers holding across idle time, a release with only one enable low, a drain while a run is open, and a stall on a full FIFO. Each of these catches a design that leaks, loses or reorders bytes.

// File: rtl/rle_pkg.sv
package rle_pkg;

  // which source feeds the FIFO write port in a cycle
  typedef enum logic [1:0] {
    EMIT_NONE  = 2'd0,
    EMIT_COUNT = 2'd1,
    EMIT_OLD   = 2'd2,
    EMIT_NEW   = 2'd3
  } emit_src_e;

  // pipeline is released when compression is off or both transfer enables are low
  function automatic logic pipe_release(logic comp_on, logic dma_on, logic buf_on);
    return !comp_on || (!dma_on && !buf_on);
  endfunction

endpackage

// File: rtl/rle_hold_pipe.sv
module rle_hold_pipe #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [DATA_W-1:0] din,
  input  logic              drain,
  output logic [DATA_W-1:0] old_q,
  output logic              old_v,
  output logic [DATA_W-1:0] new_q,
  output logic              new_v
);

  always_ff @(posedge clk) begin
    if (rst) begin
      old_q <= '0;
      old_v <= 1'b0;
      new_q <= '0;
      new_v <= 1'b0;
    end else if (take) begin
      old_q <= new_q;
      old_v <= new_v;
      new_q <= din;
      new_v <= 1'b1;
    end else if (drain) begin
      // the older byte (or the newer one if alone) has just been written out
      old_q <= new_q;
      old_v <= old_v && new_v;
      new_v <= 1'b0;
    end
  end

endmodule

// File: rtl/rle_run_ctr.sv
module rle_run_ctr #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             extend,
  input  logic             close,
  input  logic             lit_sent,
  output logic [CNT_W-1:0] cnt,
  output logic             lit_due
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      lit_due <= 1'b0;
    end else begin
      if (lit_sent) lit_due <= 1'b0;
      if (close) begin
        cnt     <= '0;
        lit_due <= 1'b1;
      end else if (start) begin
        cnt <= CNT_W'(1);
      end else if (extend) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rle_tx_packer.sv
module rle_tx_packer #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              comp_en,
  input  logic              dma_en,
  input  logic              buf_we_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              fifo_full,
  output logic              fifo_wr,
  output logic [DATA_W:0]   fifo_data
);
  import rle_pkg::*;

  localparam logic [CNT_W-1:0] RUN_MAX = '1;

  logic [DATA_W-1:0] old_q, new_q;
  logic              old_v, new_v;
  logic [CNT_W-1:0]  run_cnt;
  logic              lit_due;

  // three equal bytes across older, newer and offered
  function automatic logic triple_match(logic ov, logic nv, logic [DATA_W-1:0] o,
                                        logic [DATA_W-1:0] n, logic [DATA_W-1:0] x);
    return ov && nv && (o == n) && (n == x);
  endfunction

  // an open run must close on a new value, at the cap, or when compression drops
  function automatic logic run_must_close(logic [CNT_W-1:0] c, logic [DATA_W-1:0] held,
                                          logic [DATA_W-1:0] x, logic on);
    return (c == RUN_MAX) || (x != held) || !on;
  endfunction

  // named internal events
  logic      release_req, in_run, run_brk, room;
  logic      take, ev_start, ev_extend, ev_end, ev_lit, ev_drain;
  emit_src_e emit_sel;

  always_comb begin
    release_req = pipe_release(comp_en, dma_en, buf_we_en);
    in_run      = (run_cnt != '0);
    room        = !fifo_full;
    run_brk     = in_run && run_must_close(run_cnt, new_q, wr_data, comp_en);
    wr_ready    = room && !run_brk;
    take        = wr_en && wr_ready;
    ev_end      = room && in_run && (wr_en ? run_brk : release_req);
    ev_start    = take && !in_run && !lit_due && comp_en &&
                  triple_match(old_v, new_v, old_q, new_q, wr_data);
    ev_extend   = take && in_run;
    ev_lit      = take && !ev_start && !ev_extend && old_v;
    ev_drain    = room && !wr_en && release_req && !in_run && (old_v || new_v);
  end

  always_comb begin
    if (ev_end)                emit_sel = EMIT_COUNT;
    else if (ev_lit)           emit_sel = EMIT_OLD;
    else if (ev_drain && old_v) emit_sel = EMIT_OLD;
    else if (ev_drain)         emit_sel = EMIT_NEW;
    else                       emit_sel = EMIT_NONE;
  end

  always_comb begin
    fifo_wr = (emit_sel != EMIT_NONE);
    case (emit_sel)
      EMIT_COUNT: fifo_data = {1'b1, DATA_W'(run_cnt)};
      EMIT_OLD:   fifo_data = {1'b0, old_q};
      EMIT_NEW:   fifo_data = {1'b0, new_q};
      default:    fifo_data = '0;
    endcase
  end

  rle_hold_pipe #(.DATA_W(DATA_W)) u_pipe (
    .clk   (clk),
    .rst   (rst),
    .take  (take),
    .din   (wr_data),
    .drain (ev_drain),
    .old_q (old_q),
    .old_v (old_v),
    .new_q (new_q),
    .new_v (new_v)
  );

  rle_run_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .start    (ev_start),
    .extend   (ev_extend),
    .close    (ev_end),
    .lit_sent (ev_lit || ev_drain),
    .cnt      (run_cnt),
    .lit_due  (lit_due)
  );

endmodule

// File: rtl/rle_tx_packer_chk.sv
module rle_tx_packer_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             comp_en,
  input logic             dma_en,
  input logic             buf_we_en,
  input logic             wr_en,
  input logic             wr_ready,
  input logic             fifo_full,
  input logic             fifo_wr,
  input logic [DATA_W:0]  fifo_data,
  input logic [CNT_W-1:0] run_cnt,
  input logic             ev_start
);

  logic cnt_wr;
  assign cnt_wr = fifo_wr && fifo_data[DATA_W];

  // R2: count entries are nonzero and fit the counter width
  p_count_field_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |-> (fifo_data[DATA_W-1:0] != '0) && ((fifo_data[DATA_W-1:0] >> CNT_W) == '0));

  // R2: a count is never followed by another count
  p_count_then_literal_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> !cnt_wr);

  // R3: starting a run writes nothing
  p_start_silent_r3: assert property (@(posedge clk) disable iff (rst)
    ev_start |-> !fifo_wr);

  // R6: the counter only steps by one, holds, or clears
  p_cnt_steps_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (run_cnt == '0) || (run_cnt == $past(run_cnt)) ||
             (run_cnt == CNT_W'($past(run_cnt) + 1'b1)));

  // R7: no release and no offered byte means no FIFO write
  p_hold_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && comp_en && (dma_en || buf_we_en)) |-> !fifo_wr);

  // R9: with compression off and no open run, no count appears
  p_no_count_off_r9: assert property (@(posedge clk) disable iff (rst)
    (!comp_en && run_cnt == '0) |-> !cnt_wr);

  // R10: a full FIFO blocks both sides
  p_full_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> (!fifo_wr && !wr_ready));

  // R11: an offered byte is held back while its run's count is written
  p_count_stalls_r11: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && wr_en) |-> !wr_ready);

endmodule

bind rle_tx_packer rle_tx_packer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .comp_en   (comp_en),
  .dma_en    (dma_en),
  .buf_we_en (buf_we_en),
  .wr_en     (wr_en),
  .wr_ready  (wr_ready),
  .fifo_full (fifo_full),
  .fifo_wr   (fifo_wr),
  .fifo_data (fifo_data),
  .run_cnt   (run_cnt),
  .ev_start  (ev_start)
);

// File: tb/rle_tx_packer_test.sv
module rle_tx_packer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int CW = 7;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst, comp_en, dma_en, buf_we_en, wr_en, wr_ready, fifo_full, fifo_wr;
  logic [DW-1:0] wr_data;
  logic [DW:0]   fifo_data;

  rle_tx_packer #(.DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .comp_en(comp_en), .dma_en(dma_en), .buf_we_en(buf_we_en),
    .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready), .fifo_full(fifo_full),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [DW:0] got_q[$];
  logic [DW:0] exp_q[$];
  int sent_len = 0;

  function automatic logic [DW:0] lit(int b);
    return {1'b0, DW'(b)};
  endfunction
  function automatic logic [DW:0] cnt(int n);
    return {1'b1, DW'(n)};
  endfunction

  task automatic check(string req, int act, int expv, string what);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // sample a quarter period after the falling edge, then advance one cycle
  task automatic step();
    #(CLK_PERIOD/4);
    if (fifo_wr) got_q.push_back(fifo_data);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(int b, output int stalls);
    bit acc;
    stalls = 0;
    wr_en = 1'b1;
    wr_data = DW'(b);
    do begin
      #(CLK_PERIOD/4);
      if (fifo_wr) got_q.push_back(fifo_data);
      acc = wr_ready;
      if (!acc) stalls++;
      @(posedge clk);
      @(negedge clk);
    end while (!acc);
    wr_en = 1'b0;
    sent_len++;
  endtask

  task automatic push_n(int b, int n);
    int s;
    for (int i = 0; i < n; i++) push(b, s);
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  task automatic drain_all();
    comp_en = 1'b1; dma_en = 1'b0; buf_we_en = 1'b0;
    idle(6);
    dma_en = 1'b1; buf_we_en = 1'b1;
  endtask

  function automatic int decoded_len();
    int total = 0;
    int rep = 1;
    foreach (got_q[i]) begin
      if (got_q[i][DW]) rep = int'(got_q[i][DW-1:0]) + 1;
      else begin
        total += rep;
        rep = 1;
      end
    end
    return total;
  endfunction

  task automatic compare(string req);
    check(req, got_q.size(), exp_q.size(), "entry count");
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(req, int'(got_q[i]), int'(exp_q[i]), $sformatf("entry %0d", i));
    got_q.delete();
    exp_q.delete();
    sent_len = 0;
  endtask

  task automatic t_reset();
    #(CLK_PERIOD/4);
    check("R1", int'(fifo_wr), 0, "fifo_wr after reset");
    check("R1", int'(wr_ready), 1, "wr_ready after reset");
    @(posedge clk); @(negedge clk);
    idle(3);
    compare("R1");
  endtask

  task automatic t_hold_and_release();
    push_n(8'h01, 1); push_n(8'h02, 1); push_n(8'h03, 1); push_n(8'h04, 1);
    idle(5);
    exp_q.push_back(lit(1)); exp_q.push_back(lit(2));
    compare("R7");
    dma_en = 1'b0;
    idle(4);
    compare("R7");
    buf_we_en = 1'b0;
    idle(4);
    exp_q.push_back(lit(3)); exp_q.push_back(lit(4));
    compare("R8");
    dma_en = 1'b1; buf_we_en = 1'b1;
  endtask

  task automatic t_pair_only();
    push_n(8'h09, 2); push_n(8'h05, 1);
    drain_all();
    exp_q.push_back(lit(9)); exp_q.push_back(lit(9)); exp_q.push_back(lit(5));
    compare("R3");
  endtask

  task automatic t_triple_break();
    int s;
    push_n(8'h07, 3);
    push(8'h08, s);
    check("R11", s, 1, "stall cycles on run close");
    drain_all();
    check("R4", decoded_len(), sent_len, "decoded length");
    exp_q.push_back(cnt(1)); exp_q.push_back(lit(7));
    exp_q.push_back(lit(7)); exp_q.push_back(lit(8));
    compare("R5");
  endtask

  task automatic t_long_run();
    push_n(8'hAA, 131);
    drain_all();
    check("R4", decoded_len(), sent_len, "decoded length of long run");
    exp_q.push_back(cnt(127)); exp_q.push_back(lit(8'hAA));
    exp_q.push_back(cnt(1));   exp_q.push_back(lit(8'hAA));
    exp_q.push_back(lit(8'hAA));
    compare("R6");
  endtask

  task automatic t_passthrough();
    comp_en = 1'b0;
    push_n(8'h03, 4); push_n(8'h04, 1);
    idle(6);
    for (int i = 0; i < 4; i++) exp_q.push_back(lit(3));
    exp_q.push_back(lit(4));
    compare("R9");
    comp_en = 1'b1;
  endtask

  task automatic t_full_stall();
    push_n(8'h10, 1); push_n(8'h20, 1);
    fifo_full = 1'b1;
    wr_en = 1'b1; wr_data = 8'h30;
    for (int i = 0; i < 3; i++) begin
      #(CLK_PERIOD/4);
      check("R10", int'(wr_ready), 0, "wr_ready while full");
      check("R10", int'(fifo_wr), 0, "fifo_wr while full");
      @(posedge clk); @(negedge clk);
    end
    fifo_full = 1'b0;
    wr_en = 1'b0;
    push_n(8'h30, 1);
    drain_all();
    exp_q.push_back(lit(8'h10)); exp_q.push_back(lit(8'h20)); exp_q.push_back(lit(8'h30));
    compare("R10");
  endtask

  task automatic t_disable_mid_run();
    push_n(8'h06, 4);
    comp_en = 1'b0;
    idle(6);
    exp_q.push_back(cnt(2)); exp_q.push_back(lit(6)); exp_q.push_back(lit(6));
    compare("R8");
    comp_en = 1'b1;
  endtask

  initial begin
    rst = 1'b1; comp_en = 1'b1; dma_en = 1'b1; buf_we_en = 1'b1;
    wr_en = 1'b0; wr_data = '0; fifo_full = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_hold_and_release();
    t_pair_only();
    t_triple_break();
    t_long_run();
    t_passthrough();
    t_full_stall();
    t_disable_mid_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule